// File: doc/BRIEF.md
# Exception Return Address Register

This block keeps the address at which execution resumes after an exception or interrupt. When the pipeline takes an exception it strobes the block with a cause code and two candidate addresses: the PC of the instruction that did not complete, and the PC of the instruction after it. The block saves the right one. Privileged software can also read and overwrite the register through a move-to/move-from register port. A return-from-exception strobe switches the processor mode from the saved state.

Instruction addresses are longword aligned, so the two low bits of the stored word carry extra state. Bit 0 holds the mode of the interrupted code: 1 means privileged and 0 means native. Bit 1 holds an exactness indicator. It is meaningful only for arithmetic traps and machine checks, which can pre-empt a call into privileged code and so leave a saved address that is 4 too large. The block applies that correction itself. It presents a ready-to-use return target, the mode the return restores, the current privilege state and an address-translation enable.

Top module: `exc_ret_addr`

## Requirements
- R1: After reset the stored word is zero, `sw_rd_data` and `ret_pc` read zero, `priv_mode` is 1 and `xlate_en` is 0.
- R2: Cause codes are 0 interrupt, 1 fault, 2 call to privileged code, 3 arithmetic trap and 4 machine check. An exception with any cause other than 2 stores `exc_fault_pc[W-1:2]` into bits W-1:2 and `exc_from_priv` into bit 0. The new value is visible on `sw_rd_data` one cycle after the strobe.
- R3: An exception with cause 2 stores `exc_next_pc[W-1:2]` into bits W-1:2 instead of the faulting PC.
- R4: A software write with no exception in the same cycle stores all W bits of `sw_wr_data`. The value is readable on `sw_rd_data` the next cycle.
- R5: When an exception and a software write fall in the same cycle, the exception value is stored and the software data is discarded.
- R6: `ret_pc` always has bits 1:0 at zero. `ret_mode` always equals bit 0 of the stored word.
- R7: For cause 3 or 4, bit 1 stores `exc_pc_exact`. While that entry is held, `ret_pc` equals the stored address minus 4 (modulo 2^W) when bit 1 is 0, and equals the stored address when bit 1 is 1.
- R8: For causes 0, 1 and 2, bit 1 is stored as 0 whatever `exc_pc_exact` is, and `ret_pc` is the stored address with no adjustment.
- R9: A return strobe while bit 0 of the stored word is 0 makes `priv_mode` 0 and `xlate_en` 1 from the next cycle.
- R10: A return strobe while bit 0 is 1 leaves `priv_mode` at 1 and `xlate_en` at 0.
- R11: An exception drives `priv_mode` to 1 and `xlate_en` to 0 on the next cycle. This holds even if a return strobe comes in the same cycle.
- R12: A value written by software is never adjusted: `ret_pc` is that value with bits 1:0 cleared, even when bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid | input | 1 | Exception taken this cycle |
| exc_cause | input | CAUSE_W | Cause code of the exception |
| exc_fault_pc | input | ADDR_W | PC of the instruction that did not complete |
| exc_next_pc | input | ADDR_W | PC of the following instruction |
| exc_from_priv | input | 1 | Interrupted code was privileged |
| exc_pc_exact | input | 1 | Trap or machine check did not pre-empt a call |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | ADDR_W | Software write data |
| rei | input | 1 | Return-from-exception strobe |
| sw_rd_data | output | ADDR_W | Stored word, for software reads |
| ret_pc | output | ADDR_W | Return target, corrected and aligned |
| ret_mode | output | 1 | Mode the return restores (1 = privileged) |
| priv_mode | output | 1 | Current privileged-mode state |
| xlate_en | output | 1 | Address translation enabled |

## Verification
The bench builds the block with a 32-bit address and a 3-bit cause field, with correction enabled. The narrow width puts the wrap-around case in reach: a trap saved at address zero with the indicator clear must return 0xFFFFFFFC. The bench also checks the same-cycle collisions, exception against software write and exception against return. It confirms that software-written values with bit 1 clear are never adjusted.

// File: rtl/exc_ret_pkg.sv
package exc_ret_pkg;

   localparam int unsigned CAUSE_INTR  = 0;
   localparam int unsigned CAUSE_FAULT = 1;
   localparam int unsigned CAUSE_CALL  = 2;
   localparam int unsigned CAUSE_ARITH = 3;
   localparam int unsigned CAUSE_MCHK  = 4;

   localparam int unsigned MIN_ADDR_W  = 8;
   localparam int unsigned MIN_CAUSE_W = 3;

   typedef enum logic [1:0] {
      SRC_HOLD = 2'd0,
      SRC_HW   = 2'd1,
      SRC_SW   = 2'd2
   } wr_src_e;

endpackage

// File: rtl/exc_ret_capture.sv
module exc_ret_capture #(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned CAUSE_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exc_valid,
   input  logic [CAUSE_W-1:0] exc_cause,
   input  logic [ADDR_W-1:0]  exc_fault_pc,
   input  logic [ADDR_W-1:0]  exc_next_pc,
   input  logic               exc_from_priv,
   input  logic               exc_pc_exact,
   input  logic               sw_wr_en,
   input  logic [ADDR_W-1:0]  sw_wr_data,
   output logic [ADDR_W-1:0]  addr_q,
   output logic               trap_q
);
   import exc_ret_pkg::*;

   localparam int unsigned PC_HI = ADDR_W - 1;

   logic                is_call;
   logic                is_trap;
   logic [ADDR_W-1:0]   sel_pc;
   logic [ADDR_W-1:0]   hw_val;
   wr_src_e             src;
   logic [1:0]          unused_sel_lo;

   always_comb begin
      is_call = (exc_cause == CAUSE_W'(CAUSE_CALL));
      is_trap = (exc_cause == CAUSE_W'(CAUSE_ARITH)) ||
                (exc_cause == CAUSE_W'(CAUSE_MCHK));
      sel_pc  = is_call ? exc_next_pc : exc_fault_pc;
      hw_val  = {sel_pc[PC_HI:2], is_trap & exc_pc_exact, exc_from_priv};
      if (exc_valid)     src = SRC_HW;
      else if (sw_wr_en) src = SRC_SW;
      else               src = SRC_HOLD;
   end

   assign unused_sel_lo = sel_pc[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         trap_q <= 1'b0;
      end else begin
         case (src)
            SRC_HW: begin
               addr_q <= hw_val;
               trap_q <= is_trap;
            end
            SRC_SW: begin
               addr_q <= sw_wr_data;
               trap_q <= 1'b0;
            end
            default: begin
               addr_q <= addr_q;
               trap_q <= trap_q;
            end
         endcase
      end
   end

   a_r2_fault_pc_saved: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid && (exc_cause != CAUSE_W'(CAUSE_CALL)) |=>
         addr_q[PC_HI:2] == $past(exc_fault_pc[PC_HI:2]) &&
         addr_q[0] == $past(exc_from_priv));

   a_r3_call_next_pc: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid && (exc_cause == CAUSE_W'(CAUSE_CALL)) |=>
         addr_q[PC_HI:2] == $past(exc_next_pc[PC_HI:2]));

   a_r4_sw_store: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr_en && !exc_valid |=> addr_q == $past(sw_wr_data) && !trap_q);

   a_r5_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid && sw_wr_en |=> trap_q == $past(is_trap) &&
         addr_q[0] == $past(exc_from_priv));

   a_r8_bit1_clear: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid && !is_trap |=> !addr_q[1]);

   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_valid && !sw_wr_en |=> $stable(addr_q) && $stable(trap_q));

endmodule

// File: rtl/exc_ret_target.sv
module exc_ret_target #(
   parameter int unsigned ADDR_W     = 64,
   parameter bit          CORRECT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic              trap_q,
   output logic [ADDR_W-1:0] ret_pc,
   output logic              ret_mode
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

   logic [ADDR_W-1:0] aligned;

   assign aligned  = {addr_q[ADDR_W-1:2], 2'b00};
   assign ret_mode = addr_q[0];

   generate
      if (CORRECT_EN) begin : g_correct
         logic need_fix;
         assign need_fix = trap_q & ~addr_q[1];
         assign ret_pc   = need_fix ? (aligned - STEP) : aligned;
      end else begin : g_plain
         logic unused_trap;
         assign unused_trap = trap_q;
         assign ret_pc      = aligned;
      end
   endgenerate

   a_r8_no_adjust: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_q |-> ret_pc == {addr_q[ADDR_W-1:2], 2'b00});

   a_r7_exact_no_adjust: assert property (@(posedge clk) disable iff (!rst_n)
      trap_q && addr_q[1] |-> ret_pc[ADDR_W-1:2] == addr_q[ADDR_W-1:2]);

   a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      ret_pc[1:0] == 2'b00);

endmodule

// File: rtl/exc_ret_mode.sv
module exc_ret_mode (
   input  logic clk,
   input  logic rst_n,
   input  logic exc_valid,
   input  logic rei,
   input  logic saved_mode,
   output logic priv_mode,
   output logic xlate_en
);
   logic priv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         priv_q <= 1'b1;
      else if (exc_valid) priv_q <= 1'b1;
      else if (rei)       priv_q <= saved_mode;
      else                priv_q <= priv_q;
   end

   assign priv_mode = priv_q;
   assign xlate_en  = ~priv_q;

   a_r11_exc_priv: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> priv_mode && !xlate_en);

   a_r9_rei_native: assert property (@(posedge clk) disable iff (!rst_n)
      rei && !exc_valid && !saved_mode |=> !priv_mode && xlate_en);

   a_r10_rei_stays_priv: assert property (@(posedge clk) disable iff (!rst_n)
      rei && saved_mode |=> priv_mode && !xlate_en);

   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rei && !exc_valid |=> $stable(priv_mode));

endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned CAUSE_W    = 3,
   parameter bit          CORRECT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exc_valid,
   input  logic [CAUSE_W-1:0] exc_cause,
   input  logic [ADDR_W-1:0]  exc_fault_pc,
   input  logic [ADDR_W-1:0]  exc_next_pc,
   input  logic               exc_from_priv,
   input  logic               exc_pc_exact,
   input  logic               sw_wr_en,
   input  logic [ADDR_W-1:0]  sw_wr_data,
   input  logic               rei,
   output logic [ADDR_W-1:0]  sw_rd_data,
   output logic [ADDR_W-1:0]  ret_pc,
   output logic               ret_mode,
   output logic               priv_mode,
   output logic               xlate_en
);
   import exc_ret_pkg::*;

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
         $error("exc_ret_addr: ADDR_W must be at least %0d", MIN_ADDR_W);
      end
      if (CAUSE_W < MIN_CAUSE_W) begin : g_bad_cause_w
         $error("exc_ret_addr: CAUSE_W must be at least %0d", MIN_CAUSE_W);
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic              trap_q;

   exc_ret_capture #(
      .ADDR_W  (ADDR_W),
      .CAUSE_W (CAUSE_W)
   ) i_capture (
      .clk           (clk),
      .rst_n         (rst_n),
      .exc_valid     (exc_valid),
      .exc_cause     (exc_cause),
      .exc_fault_pc  (exc_fault_pc),
      .exc_next_pc   (exc_next_pc),
      .exc_from_priv (exc_from_priv),
      .exc_pc_exact  (exc_pc_exact),
      .sw_wr_en      (sw_wr_en),
      .sw_wr_data    (sw_wr_data),
      .addr_q        (addr_q),
      .trap_q        (trap_q)
   );

   exc_ret_target #(
      .ADDR_W     (ADDR_W),
      .CORRECT_EN (CORRECT_EN)
   ) i_target (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_q   (addr_q),
      .trap_q   (trap_q),
      .ret_pc   (ret_pc),
      .ret_mode (ret_mode)
   );

   exc_ret_mode i_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .exc_valid  (exc_valid),
      .rei        (rei),
      .saved_mode (addr_q[0]),
      .priv_mode  (priv_mode),
      .xlate_en   (xlate_en)
   );

   assign sw_rd_data = addr_q;

   a_r6_mode_matches_read: assert property (@(posedge clk) disable iff (!rst_n)
      ret_mode == sw_rd_data[0]);

endmodule

// File: tb/test_exc_ret_addr.sv
module test_exc_ret_addr;
   localparam int unsigned W  = 32;
   localparam int unsigned CW = 3;

   typedef struct {
      logic [W-1:0] rd;
      logic [W-1:0] rpc;
      logic         rmode;
      logic         priv;
      logic         xl;
      string        tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          exc_valid = 1'b0;
   logic [CW-1:0] exc_cause = '0;
   logic [W-1:0]  exc_fault_pc = '0;
   logic [W-1:0]  exc_next_pc = '0;
   logic          exc_from_priv = 1'b0;
   logic          exc_pc_exact = 1'b0;
   logic          sw_wr_en = 1'b0;
   logic [W-1:0]  sw_wr_data = '0;
   logic          rei = 1'b0;
   logic [W-1:0]  sw_rd_data;
   logic [W-1:0]  ret_pc;
   logic          ret_mode;
   logic          priv_mode;
   logic          xlate_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   exp_t q[$];

   logic [W-1:0] m_addr = '0;
   logic         m_trap = 1'b0;
   logic         m_priv = 1'b1;

   always #5 clk = ~clk;

   exc_ret_addr #(.ADDR_W(W), .CAUSE_W(CW), .CORRECT_EN(1'b1)) i_exc_ret_addr (
      .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
      .exc_fault_pc(exc_fault_pc), .exc_next_pc(exc_next_pc),
      .exc_from_priv(exc_from_priv), .exc_pc_exact(exc_pc_exact),
      .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .rei(rei),
      .sw_rd_data(sw_rd_data), .ret_pc(ret_pc), .ret_mode(ret_mode),
      .priv_mode(priv_mode), .xlate_en(xlate_en)
   );

   task automatic step(input bit e, input int c, input logic [W-1:0] fpc,
                       input logic [W-1:0] npc, input bit fp, input bit ex,
                       input bit sw, input logic [W-1:0] swd, input bit r,
                       input string tag);
      exp_t x;
      logic [W-1:0] sel;
      bit trap;
      @(negedge clk);
      exc_valid = e; exc_cause = CW'(c); exc_fault_pc = fpc; exc_next_pc = npc;
      exc_from_priv = fp; exc_pc_exact = ex; sw_wr_en = sw; sw_wr_data = swd;
      rei = r;
      @(posedge clk);
      #1;
      exc_valid = 1'b0; sw_wr_en = 1'b0; rei = 1'b0;
      trap = (c == 3) || (c == 4);
      if (e)      m_priv = 1'b1;
      else if (r) m_priv = m_addr[0];
      if (e) begin
         sel    = (c == 2) ? npc : fpc;
         m_addr = {sel[W-1:2], trap & ex, fp};
         m_trap = trap;
      end else if (sw) begin
         m_addr = swd;
         m_trap = 1'b0;
      end
      x.rd    = m_addr;
      x.rpc   = {m_addr[W-1:2], 2'b00} - ((m_trap && !m_addr[1]) ? W'(4) : W'(0));
      x.rmode = m_addr[0];
      x.priv  = m_priv;
      x.xl    = ~m_priv;
      x.tag   = tag;
      q.push_back(x);
   endtask

   task automatic idle(input string tag);
      step(0, 0, '0, '0, 0, 0, 0, '0, 0, tag);
   endtask

   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t x;
         x = q.pop_front();
         checks++;
         if (sw_rd_data !== x.rd || ret_pc !== x.rpc || ret_mode !== x.rmode ||
             priv_mode !== x.priv || xlate_en !== x.xl) begin
            errors++;
            $display("FAIL %s: rd=%h rpc=%h mode=%b priv=%b xl=%b expected rd=%h rpc=%h mode=%b priv=%b xl=%b",
                     x.tag, sw_rd_data, ret_pc, ret_mode, priv_mode, xlate_en,
                     x.rd, x.rpc, x.rmode, x.priv, x.xl);
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      idle("R1 reset state");
      step(1, 1, 32'h1000, 32'h1004, 0, 1, 0, '0, 0, "R2 R8 fault saves faulting pc, exact ignored");
      step(0, 0, '0, '0, 0, 0, 0, '0, 1, "R9 return to native mode");
      step(1, 2, 32'h2000, 32'h2004, 0, 0, 0, '0, 0, "R3 call saves next pc");
      step(1, 3, 32'h3008, 32'h300C, 1, 0, 0, '0, 0, "R7 arith trap inexact minus 4");
      step(0, 0, '0, '0, 0, 0, 0, '0, 1, "R10 return keeps privileged");
      step(1, 4, 32'h4000, 32'h4004, 0, 1, 0, '0, 0, "R7 machine check exact");
      step(0, 0, '0, '0, 0, 0, 1, 32'h5001, 0, "R4 R12 sw write no adjust");
      idle("R6 target masks low bits, mode from bit 0");
      step(1, 0, 32'h7000, 32'h7004, 1, 0, 1, 32'h6000, 0, "R5 exception beats sw write");
      step(0, 0, '0, '0, 0, 0, 1, 32'h8000, 0, "R4 sw write native target");
      step(0, 0, '0, '0, 0, 0, 0, '0, 1, "R9 return native again");
      step(1, 1, 32'h9000, 32'h9004, 0, 0, 0, '0, 1, "R11 exception beats return");
      step(1, 3, 32'h0000, 32'h0004, 1, 0, 0, '0, 0, "R7 wrap at zero");
      step(0, 0, '0, '0, 0, 0, 1, 32'hABCD0002, 1, "R4 R10 sw write with return uses old mode");
      idle("R12 sw bit1 set no adjust");
      step(1, 2, 32'hC000, 32'hC004, 1, 1, 0, '0, 0, "R8 call bit1 cleared");
      idle("R6 final hold");
      repeat (2) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule